// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block connects three 8-bit parallel ports to a CPU bus with an 8-bit data path, two address bits and active-low chip select, read and write strobes. Port A and port B each have a full byte of direction. Port C is split into an upper nibble (bits 7-4) and a lower nibble (bits 3-0), and each nibble has its own direction. The upper nibble is grouped with port A and the lower nibble with port B.

Software programs the block through one command address. The top bit of each word written there chooses its meaning. When it is set, the word configures the direction of all four port sections. When it is clear, the word sets or clears a single port C output bit. On the peripheral side every port has separate input, output and output-enable vectors, so the block contains no tri-state logic. Only basic mode is implemented: outputs are held in latches and inputs are read straight from the pins. Command words that request the strobed or bidirectional modes still give basic-mode behaviour.

Top module: `ppio_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes every port an input: all `*_oe` bits are 0. It also clears every output latch (all `*_out` bits are 0), and `dout_en` is 0 while no read is in progress.
- R2: A write of a command word with bit 7 = 1 at address 3 sets the directions, with 1 meaning input: bit 4 controls port A, bit 3 the upper nibble of C, bit 1 port B and bit 0 the lower nibble of C. An output section drives all of its `*_oe` bits to 1. Bits 6, 5 and 2 have no effect on any port.
- R3: Writing a direction word clears the output latches of ports A, B and C.
- R4: A write to address 0, 1 or 2 stores the data byte in the latch of port A, B or C. The byte appears on `*_out` after that clock edge and stays there until the next write that changes it.
- R5: Reading a port section that is set as input returns the current pin values, with no latching. A change on the pins is seen by the next read.
- R6: Reading a port section that is set as output returns its latch contents. A port C read combines the two nibbles, each taken according to its own direction.
- R7: A command word with bit 7 = 0 written at address 3 changes only the port C latch bit whose number is in bits 3-1, setting it to the value in bit 0. No other latch bit and no direction changes.
- R8: A read at address 3 returns 0x00.
- R9: While `cs_n` is high, writes change no latch and no direction.
- R10: `dout_en` is 1 exactly when `cs_n` is low, `rd_n` is low and `wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write takes effect at each clock edge while the write strobe and chip select are both low |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 command |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU |
| dout_en | output | 1 | Drive enable for the CPU data bus |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench uses the default parameters: an 8-bit data width and the combinational read path (`READ_REG = 0`). With these settings a read can be sampled in the same cycle in which it is driven. That lets the bench compare live pin changes and nibble-mixed port C reads against expected values that it works out independently. It also lets the checker enforce the zero result for a command-address read. The registered read variant adds one cycle of latency and is not built by this bench.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

   // Direction of each port section; 1 means input
   typedef struct packed {
      logic a_in;
      logic cu_in;
      logic b_in;
      logic cl_in;
   } ppio_dir_t;

   localparam logic [1:0] SEL_PA  = 2'd0;
   localparam logic [1:0] SEL_PB  = 2'd1;
   localparam logic [1:0] SEL_PC  = 2'd2;
   localparam logic [1:0] SEL_CMD = 2'd3;

   // Command word field positions
   localparam int CW_KIND = 7;
   localparam int CW_A    = 4;
   localparam int CW_CU   = 3;
   localparam int CW_B    = 1;
   localparam int CW_CL   = 0;

   localparam ppio_dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppio_ctl_reg.sv
module ppio_ctl_reg
   import ppio_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_wr,
   input  logic             kind,
   input  logic [3:0]       dir_bits,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_val,
   output ppio_dir_t        dir,
   output logic             clr_all,
   output logic             bit_op,
   output logic [SEL_W-1:0] bit_idx,
   output logic             bit_new
);

   ppio_dir_t dir_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= DIR_ALL_IN;
      end else if (cmd_wr && kind) begin
         dir_q <= dir_bits;
      end
   end

   assign dir     = dir_q;
   assign clr_all = cmd_wr && kind;
   assign bit_op  = cmd_wr && !kind;
   assign bit_idx = bit_sel;
   assign bit_new = bit_val;

endmodule

// File: rtl/ppio_out_latch.sv
module ppio_out_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         q_r <= '0;
      end else begin
         q_r <= (q_r & ~mask) | (wdata & mask);
      end
   end

   assign q = q_r;

endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
   import ppio_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        addr,
   input  ppio_dir_t         dir,
   input  logic [DATA_W-1:0] pa_pin,
   input  logic [DATA_W-1:0] pa_lat,
   input  logic [DATA_W-1:0] pb_pin,
   input  logic [DATA_W-1:0] pb_lat,
   input  logic [DATA_W-1:0] pc_pin,
   input  logic [DATA_W-1:0] pc_lat,
   output logic [DATA_W-1:0] rdata
);

   localparam int NIB_W = DATA_W / 2;

   logic [DATA_W-1:0] a_val, b_val, c_val;

   always_comb begin
      a_val = dir.a_in ? pa_pin : pa_lat;
      b_val = dir.b_in ? pb_pin : pb_lat;
      c_val[DATA_W-1:NIB_W] = dir.cu_in ? pc_pin[DATA_W-1:NIB_W] : pc_lat[DATA_W-1:NIB_W];
      c_val[NIB_W-1:0]      = dir.cl_in ? pc_pin[NIB_W-1:0]      : pc_lat[NIB_W-1:0];
      unique case (addr)
         SEL_PA:  rdata = a_val;
         SEL_PB:  rdata = b_val;
         SEL_PC:  rdata = c_val;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);

   localparam int NIB_W = DATA_W / 2;
   localparam int SEL_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("ppio_ctrl: command word layout needs DATA_W of 8");
   end

   logic              wr_act, rd_act;
   ppio_dir_t         dir;
   logic              clr_all, bit_op, bit_new;
   logic [SEL_W-1:0]  bit_idx;
   logic [DATA_W-1:0] a_mask, b_mask, c_mask, c_wdata, onehot;
   logic [DATA_W-1:0] rdata;

   assign wr_act = !cs_n && !wr_n;
   assign rd_act = !cs_n && !rd_n && wr_n;

   ppio_ctl_reg #(.SEL_W(SEL_W)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .cmd_wr   (wr_act && (addr == SEL_CMD)),
      .kind     (din[CW_KIND]),
      .dir_bits ({din[CW_A], din[CW_CU], din[CW_B], din[CW_CL]}),
      .bit_sel  (din[SEL_W:1]),
      .bit_val  (din[0]),
      .dir      (dir),
      .clr_all  (clr_all),
      .bit_op   (bit_op),
      .bit_idx  (bit_idx),
      .bit_new  (bit_new)
   );

   always_comb begin
      onehot = '0;
      onehot[bit_idx] = 1'b1;
   end

   assign a_mask  = {DATA_W{wr_act && (addr == SEL_PA)}};
   assign b_mask  = {DATA_W{wr_act && (addr == SEL_PB)}};
   assign c_mask  = {DATA_W{wr_act && (addr == SEL_PC)}} | (bit_op ? onehot : '0);
   assign c_wdata = bit_op ? {DATA_W{bit_new}} : din;

   ppio_out_latch #(.W(DATA_W)) u_lat_a (
      .clk(clk), .rst(rst), .clr(clr_all), .mask(a_mask), .wdata(din), .q(pa_out)
   );
   ppio_out_latch #(.W(DATA_W)) u_lat_b (
      .clk(clk), .rst(rst), .clr(clr_all), .mask(b_mask), .wdata(din), .q(pb_out)
   );
   ppio_out_latch #(.W(DATA_W)) u_lat_c (
      .clk(clk), .rst(rst), .clr(clr_all), .mask(c_mask), .wdata(c_wdata), .q(pc_out)
   );

   assign pa_oe = {DATA_W{!dir.a_in}};
   assign pb_oe = {DATA_W{!dir.b_in}};
   assign pc_oe = {{NIB_W{!dir.cu_in}}, {NIB_W{!dir.cl_in}}};

   ppio_rd_mux #(.DATA_W(DATA_W)) u_rd (
      .addr   (addr),
      .dir    (dir),
      .pa_pin (pa_in),
      .pa_lat (pa_out),
      .pb_pin (pb_in),
      .pb_lat (pb_out),
      .pc_pin (pc_in),
      .pc_lat (pc_out),
      .rdata  (rdata)
   );

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] dout_q;
      always_ff @(posedge clk) begin
         if (rst) dout_q <= '0;
         else     dout_q <= rd_act ? rdata : '0;
      end
      assign dout = dout_q;
   end else begin : g_rd_comb
      assign dout = rd_act ? rdata : '0;
   end

   assign dout_en = rd_act;

endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic [DATA_W-1:0] pa_out,
   input logic [DATA_W-1:0] pa_oe,
   input logic [DATA_W-1:0] pb_out,
   input logic [DATA_W-1:0] pb_oe,
   input logic [DATA_W-1:0] pc_out,
   input logic [DATA_W-1:0] pc_oe
);

   logic cmd_wr;
   assign cmd_wr = !cs_n && !wr_n && (addr == 2'd3);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
               pa_out == '0 && pb_out == '0 && pc_out == '0));

   a_r3_mode_clears: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && din[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

   a_r4_port_a_store: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !wr_n && addr == 2'd0) |=> (pa_out == $past(din)));

   a_r7_single_bit: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !din[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                               $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                               $stable(pa_out) && $stable(pb_out)));

   a_r9_deselect_stable: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   a_r10_en_needs_read: assert property (@(posedge clk) disable iff (rst)
      dout_en |-> (!cs_n && !rd_n && wr_n));

   a_r10_read_drives: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !rd_n && wr_n) |-> dout_en);

   if (!READ_REG) begin : g_comb_chk
      a_r8_cmd_read_zero: assert property (@(posedge clk) disable iff (rst)
         (dout_en && addr == 2'd3) |-> (dout == '0));
   end

endmodule

bind ppio_ctrl ppio_ctrl_chk #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_chk (.*);

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb;

   localparam int PERIOD = 10;
   localparam int NV = 24;

   // entry = {is_write, addr[1:0], data}; for reads data is the expected value
   localparam logic [10:0] TBL [NV] = '{
      {1'b1, 2'd3, 8'h9B},  // R2 all inputs
      {1'b0, 2'd0, 8'h5A},  // R5
      {1'b0, 2'd1, 8'hC3},  // R5
      {1'b0, 2'd2, 8'h96},  // R5
      {1'b0, 2'd3, 8'h00},  // R8
      {1'b1, 2'd3, 8'h80},  // R2 all outputs
      {1'b1, 2'd0, 8'h11},  // R4
      {1'b1, 2'd1, 8'h22},  // R4
      {1'b1, 2'd2, 8'h33},  // R4
      {1'b0, 2'd0, 8'h11},  // R6
      {1'b0, 2'd1, 8'h22},  // R6
      {1'b0, 2'd2, 8'h33},  // R6
      {1'b1, 2'd3, 8'h0F},  // R7 set bit 7
      {1'b0, 2'd2, 8'hB3},  // R7
      {1'b1, 2'd3, 8'h02},  // R7 clear bit 1
      {1'b0, 2'd2, 8'hB1},  // R7
      {1'b1, 2'd3, 8'h89},  // R2 C both in, A/B out
      {1'b0, 2'd2, 8'h96},  // R6 mixed
      {1'b0, 2'd0, 8'h00},  // R3
      {1'b0, 2'd1, 8'h00},  // R3
      {1'b1, 2'd3, 8'h81},  // R2 lower C in
      {1'b1, 2'd2, 8'hFF},  // R4
      {1'b0, 2'd2, 8'hF6},  // R6 mixed
      {1'b0, 2'd3, 8'h00}   // R8
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic       dout_en;
   logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h96;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ppio_ctrl u_dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
      #(PERIOD/4);
      d = dout;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      logic [7:0] rv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1 oe", {pa_oe, pb_oe, pc_oe}, 32'h0);
      check("R1 out", {pa_out, pb_out, pc_out}, 32'h0);
      check("R1 dout_en", dout_en, 0);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i][10]) begin
            bus_write(TBL[i][9:8], TBL[i][7:0]);
         end else begin
            bus_read(TBL[i][9:8], rv);
            check($sformatf("R5/R6/R7/R8/R3 vec %0d", i), rv, TBL[i][7:0]);
         end
      end

      // R2 direction bits
      bus_write(2'd3, 8'h92);
      #1;
      check("R2 oe 0x92", {pa_oe, pb_oe, pc_oe}, {8'h00, 8'h00, 8'hFF});
      bus_write(2'd3, 8'hE4);
      #1;
      check("R2 mode bits ignored", {pa_oe, pb_oe, pc_oe}, {8'hFF, 8'hFF, 8'hFF});
      check("R3 cleared", {pa_out, pb_out, pc_out}, 32'h0);

      // R9 deselected write ignored
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hAA;
      @(negedge clk);
      wr_n = 1'b1;
      check("R9 write ignored", pa_out, 8'h00);
      cs_n = 1'b1; rd_n = 1'b0;
      #1;
      check("R9 no drive when deselected", dout_en, 0);
      rd_n = 1'b1;

      // R4 hold
      bus_write(2'd1, 8'h5C);
      repeat (4) @(negedge clk);
      check("R4 hold", pb_out, 8'h5C);

      // R7 direction untouched
      bus_write(2'd3, 8'h81);
      bus_write(2'd3, 8'h0B);
      #1;
      check("R7 oe kept", pc_oe, 8'hF0);
      check("R7 bit 5 set", pc_out, 8'h20);

      // R5 live pins
      bus_write(2'd3, 8'h90);
      pa_in = 8'h3C;
      bus_read(2'd0, rv);
      check("R5 live a", rv, 8'h3C);
      pa_in = 8'hE7;
      bus_read(2'd0, rv);
      check("R5 live change", rv, 8'hE7);

      // R10 strobe combinations
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = 2'd1;
      #1;
      check("R10 read enables", dout_en, 1);
      wr_n = 1'b0;
      #1;
      check("R10 read+write no drive", dout_en, 0);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;

      // R1 reset mid-run
      bus_write(2'd0, 8'h77);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 reset mid-run", {pa_out, pa_oe, pc_oe}, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule